// File: doc/BRIEF.md
# Reconfigurable Dual-Byte Timer with Variable-Length PWM

This block holds a pair of 8-bit counters, a low half and a high half, and a 2-bit mode input regroups them. In the split mode each half is an independent interval timer that restarts after reaching its own compare value. In the mixed mode the low half stays an interval timer while the high half becomes a free-running 8-bit pulse-width modulator. In the joined mode both halves form one 16-bit interval timer. In the variable-PWM mode the joined counter wraps after a power-of-two period of 2^(9+N) counts, where N is a 3-bit length field.

Counting is paced by a per-instruction-cycle enable. In the two joined modes a fast-select bit also lets a half-cycle tick advance the counter, so the count rate doubles. Each half owns a sticky event flag, and software clears it with a write-one-to-clear pulse. The PWM waveform leaves on one output pin. Its duty value sits in a shadow register that takes a new value only at a period boundary.

Top module: `mt_timer16`

## Requirements
- R1: After reset both counters are zero, the current mode is 0, the shadow duty is zero, `pwm_out` is low and both flags are low.
- R2: In mode 0 the low half counts 0..`lo_cmp` and the high half counts 0..`hi_cmp`, independently. Each restarts at 0 on the advance after it reaches its compare value, and that advance sets its own flag (`flag_lo` or `flag_hi`).
- R3: In mode 1 the low half behaves as in R2. The high half counts 0..255 and wraps, setting `flag_hi` on the wrap. `pwm_out` is high while the high count is below the 8-bit shadow duty.
- R4: In mode 2 the joined count {high,low} runs up to {`hi_cmp`,`lo_cmp`} and then restarts at 0, setting `flag_hi`. Each carry out of the low byte (low byte 255 and no restart) sets `flag_lo`.
- R5: In mode 3 the joined count wraps to 0 after reaching 2^(9+`len_sel`)-1, setting `flag_hi`, and low-byte carries set `flag_lo`. `pwm_out` is high while the joined count is below the 16-bit shadow duty.
- R6: An advance happens on an edge with `cnt_en` high. In modes 2 and 3 with `fast_sel` high, an edge with `half_tick` high also advances the count. In modes 0 and 1, `half_tick` has no effect.
- R7: The shadow duty is reloaded only at a PWM period boundary (high-byte wrap in mode 1, joined wrap in mode 3) or on a mode change. The mode 1 reload takes `hi_cmp` and the mode 3 reload takes `duty_var`. Changing a duty input mid-period does not alter the current period.
- R8: A shadow duty of zero keeps `pwm_out` low for the whole period.
- R9: A flag stays set until a `clr_lo`/`clr_hi` pulse clears it. A set on the same edge as a clear wins.
- R10: An edge on which `mode` differs from the current mode adopts the new mode, zeroes both counters and reloads the shadow duty. No flag is set on that edge.
- R11: In modes 0 and 2 `pwm_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Instruction-cycle advance enable |
| half_tick | input | 1 | Extra advance in the joined modes when fast_sel is set |
| fast_sel | input | 1 | Doubles the rate in modes 2 and 3 |
| mode | input | 2 | 0 split, 1 timer+PWM, 2 joined timer, 3 variable PWM |
| len_sel | input | 3 | N of the mode 3 period 2^(9+N) |
| lo_cmp | input | 8 | Low half compare value |
| hi_cmp | input | 8 | High half compare value, or mode 1 duty |
| duty_var | input | 16 | Mode 3 duty value |
| clr_lo | input | 1 | Clears flag_lo |
| clr_hi | input | 1 | Clears flag_hi |
| pwm_out | output | 1 | PWM output pin |
| flag_lo | output | 1 | Low half event flag |
| flag_hi | output | 1 | High half event flag |

## Verification
Every counter, shadow and flag update lands on the clock edge that samples the advancing inputs. `pwm_out` is a compare of registered state, so it and both flags are due at that same edge. The bench models each edge on its own from the requirements and queues the predicted pin values. A monitor compares them one nanosecond after the edge, with stimulus changed only on falling edges. The restart edge after each mode change is checked under R10.

// File: rtl/mt_pkg.sv
package mt_pkg;
   typedef enum logic [1:0] {
      MT_SPLIT   = 2'd0,
      MT_MIXED   = 2'd1,
      MT_JOINED  = 2'd2,
      MT_VARPWM  = 2'd3
   } mt_mode_e;
endpackage

// File: rtl/mt_tick_sel.sv
module mt_tick_sel (
   input  logic cnt_en,
   input  logic half_tick,
   input  logic fast_sel,
   input  logic joined_mode,
   output logic adv
);
   always_comb begin
      adv = cnt_en | (fast_sel & joined_mode & half_tick);
   end
endmodule

// File: rtl/mt_count_core.sv
module mt_count_core
   import mt_pkg::*;
#(
   parameter int HW        = 8,
   parameter int NW        = 3,
   parameter int BASE_BITS = 9
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            adv,
   input  logic [1:0]      mode,
   input  logic [NW-1:0]   len_sel,
   input  logic [HW-1:0]   lo_cmp,
   input  logic [HW-1:0]   hi_cmp,
   output logic [HW-1:0]   cnt_lo,
   output logic [HW-1:0]   cnt_hi,
   output mt_mode_e        mode_q,
   output logic            restart,
   output logic            bound,
   output logic            set_lo,
   output logic            set_hi
);
   localparam int FW    = 2 * HW;
   localparam int SPARE = FW - BASE_BITS;
   localparam int SW    = $clog2(FW + 1);
   localparam logic [FW-1:0] ALL1 = '1;
   localparam logic [HW-1:0] HMAX = '1;

   logic [FW-1:0] full, full_p1, lim, nxt_full;
   logic [HW-1:0] nxt_lo, nxt_hi;
   logic [SW-1:0] sh;

   always_comb begin
      full    = {cnt_hi, cnt_lo};
      full_p1 = full + 1'b1;
      sh      = SW'(SPARE) - SW'(len_sel);
      lim     = ALL1 >> sh;
      restart = (mode != mode_q);
   end

   always_comb begin
      nxt_lo   = cnt_lo;
      nxt_hi   = cnt_hi;
      nxt_full = full;
      set_lo   = 1'b0;
      set_hi   = 1'b0;
      bound    = 1'b0;
      if (restart) begin
         nxt_lo = '0;
         nxt_hi = '0;
      end else if (adv) begin
         unique case (mode_q)
            MT_SPLIT: begin
               if (cnt_lo == lo_cmp) begin nxt_lo = '0; set_lo = 1'b1; end
               else nxt_lo = cnt_lo + 1'b1;
               if (cnt_hi == hi_cmp) begin nxt_hi = '0; set_hi = 1'b1; end
               else nxt_hi = cnt_hi + 1'b1;
            end
            MT_MIXED: begin
               if (cnt_lo == lo_cmp) begin nxt_lo = '0; set_lo = 1'b1; end
               else nxt_lo = cnt_lo + 1'b1;
               nxt_hi = cnt_hi + 1'b1;
               if (cnt_hi == HMAX) begin set_hi = 1'b1; bound = 1'b1; end
            end
            MT_JOINED: begin
               if (full == {hi_cmp, lo_cmp}) begin
                  nxt_full = '0;
                  set_hi   = 1'b1;
               end else begin
                  nxt_full = full_p1;
                  set_lo   = (cnt_lo == HMAX);
               end
               {nxt_hi, nxt_lo} = nxt_full;
            end
            MT_VARPWM: begin
               if (full >= lim) begin
                  nxt_full = '0;
                  set_hi   = 1'b1;
                  bound    = 1'b1;
               end else begin
                  nxt_full = full_p1;
                  set_lo   = (cnt_lo == HMAX);
               end
               {nxt_hi, nxt_lo} = nxt_full;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_lo <= '0;
         cnt_hi <= '0;
         mode_q <= MT_SPLIT;
      end else begin
         cnt_lo <= nxt_lo;
         cnt_hi <= nxt_hi;
         mode_q <= mt_mode_e'(mode);
      end
   end

   AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cnt_lo == '0 && cnt_hi == '0)); // R10
endmodule

// File: rtl/mt_pwm_gen.sv
module mt_pwm_gen
   import mt_pkg::*;
#(
   parameter int HW      = 8,
   parameter bit REG_OUT = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            restart,
   input  logic            bound,
   input  logic [1:0]      mode,
   input  mt_mode_e        mode_q,
   input  logic [HW-1:0]   hi_cmp,
   input  logic [2*HW-1:0] duty_var,
   input  logic [HW-1:0]   cnt_lo,
   input  logic [HW-1:0]   cnt_hi,
   output logic            pwm_out
);
   localparam int FW = 2 * HW;

   logic [FW-1:0] duty_act, duty_new;
   logic          load, raw;

   always_comb begin
      load     = restart | bound;
      duty_new = (mode == MT_MIXED) ? {{HW{1'b0}}, hi_cmp} : duty_var;
      unique case (mode_q)
         MT_MIXED:  raw = (cnt_hi < duty_act[HW-1:0]);
         MT_VARPWM: raw = ({cnt_hi, cnt_lo} < duty_act);
         default:   raw = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    duty_act <= '0;
      else if (load) duty_act <= duty_new;
   end

   generate
      if (REG_OUT) begin : g_reg
         logic pwm_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pwm_q <= 1'b0;
            else        pwm_q <= raw;
         end
         assign pwm_out = pwm_q;
      end else begin : g_comb
         assign pwm_out = raw;
      end
   endgenerate

   AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(duty_act)); // R7
endmodule

// File: rtl/mt_timer16.sv
module mt_timer16
   import mt_pkg::*;
#(
   parameter int HW        = 8,
   parameter int NW        = 3,
   parameter int BASE_BITS = 9,
   parameter bit REG_OUT   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnt_en,
   input  logic              half_tick,
   input  logic              fast_sel,
   input  logic [1:0]        mode,
   input  logic [NW-1:0]     len_sel,
   input  logic [HW-1:0]     lo_cmp,
   input  logic [HW-1:0]     hi_cmp,
   input  logic [2*HW-1:0]   duty_var,
   input  logic              clr_lo,
   input  logic              clr_hi,
   output logic              pwm_out,
   output logic              flag_lo,
   output logic              flag_hi
);
   localparam int FW = 2 * HW;

   generate
      if (HW < 2) begin : g_bad_hw
         $error("mt_timer16: HW must be at least 2");
      end
      if (BASE_BITS <= HW) begin : g_bad_base
         $error("mt_timer16: BASE_BITS must exceed HW");
      end
      if (BASE_BITS + (2 ** NW) - 1 > FW) begin : g_bad_len
         $error("mt_timer16: longest PWM period exceeds the joined counter");
      end
   endgenerate

   logic          adv, restart, bound, set_lo, set_hi;
   logic [HW-1:0] cnt_lo, cnt_hi;
   mt_mode_e      mode_q;

   mt_tick_sel u_tick (
      .cnt_en      (cnt_en),
      .half_tick   (half_tick),
      .fast_sel    (fast_sel),
      .joined_mode (mode_q[1]),
      .adv         (adv)
   );

   mt_count_core #(.HW(HW), .NW(NW), .BASE_BITS(BASE_BITS)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (adv),
      .mode    (mode),
      .len_sel (len_sel),
      .lo_cmp  (lo_cmp),
      .hi_cmp  (hi_cmp),
      .cnt_lo  (cnt_lo),
      .cnt_hi  (cnt_hi),
      .mode_q  (mode_q),
      .restart (restart),
      .bound   (bound),
      .set_lo  (set_lo),
      .set_hi  (set_hi)
   );

   mt_pwm_gen #(.HW(HW), .REG_OUT(REG_OUT)) u_pwm (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (restart),
      .bound    (bound),
      .mode     (mode),
      .mode_q   (mode_q),
      .hi_cmp   (hi_cmp),
      .duty_var (duty_var),
      .cnt_lo   (cnt_lo),
      .cnt_hi   (cnt_hi),
      .pwm_out  (pwm_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_lo <= 1'b0;
         flag_hi <= 1'b0;
      end else begin
         flag_lo <= set_lo | (flag_lo & ~clr_lo);
         flag_hi <= set_hi | (flag_hi & ~clr_hi);
      end
   end

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_lo && !clr_lo) |=> flag_lo); // R9
   AST_BOUND_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      bound |=> flag_hi); // R5
   AST_SLOW_MODES: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == mode_q && !mode_q[1] && !cnt_en) |=> $stable({cnt_hi, cnt_lo})); // R6
endmodule

// File: tb/sim_mt_timer16.sv
module sim_mt_timer16;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cnt_en = 1'b0, half_tick = 1'b0, fast_sel = 1'b0;
   logic [1:0]  mode = 2'd0;
   logic [2:0]  len_sel = 3'd0;
   logic [7:0]  lo_cmp = 8'd0, hi_cmp = 8'd0;
   logic [15:0] duty_var = 16'd0;
   logic        clr_lo = 1'b0, clr_hi = 1'b0;
   logic        pwm_out, flag_lo, flag_hi;

   always #2 clk = ~clk;

   mt_timer16 u0 (
      .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .half_tick(half_tick),
      .fast_sel(fast_sel), .mode(mode), .len_sel(len_sel), .lo_cmp(lo_cmp),
      .hi_cmp(hi_cmp), .duty_var(duty_var), .clr_lo(clr_lo), .clr_hi(clr_hi),
      .pwm_out(pwm_out), .flag_lo(flag_lo), .flag_hi(flag_hi)
   );

   typedef struct {
      logic  pwm;
      logic  flo;
      logic  fhi;
      string tag;
   } exp_t;

   exp_t q[$];
   event ev_push;
   int   total = 0, bad = 0;
   bit   done = 0;

   // independent model state
   int m_mode = 0, m_lo = 0, m_hi = 0, m_duty = 0;
   bit m_flo = 0, m_fhi = 0;

   task automatic chk(string tag, logic a_p, logic a_l, logic a_h,
                      logic e_p, logic e_l, logic e_h);
      total++;
      if ({a_p, a_l, a_h} !== {e_p, e_l, e_h}) begin
         bad++;
         $display("FAIL %s: pwm/flo/fhi actual=%b%b%b expected=%b%b%b at %0t",
                  tag, a_p, a_l, a_h, e_p, e_l, e_h, $time);
      end
   endtask

   // monitor: pops predictions once the edge has settled
   initial begin
      forever begin
         @(ev_push);
         #1;
         while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk(e.tag, pwm_out, flag_lo, flag_hi, e.pwm, e.flo, e.fhi);
         end
      end
   end

   // driver side: predicts one edge and queues the result
   task automatic step(string tag_in);
      string tag;
      bit adv, slo, shi;
      int v, lim;
      exp_t e;
      tag = tag_in;
      @(posedge clk);
      adv = cnt_en | (fast_sel & (m_mode >= 2) & half_tick);
      slo = 0; shi = 0;
      if (int'(mode) != m_mode) begin
         m_lo = 0; m_hi = 0; m_mode = int'(mode);
         m_duty = (m_mode == 1) ? int'(hi_cmp) : int'(duty_var);
         tag = "R10";
      end else if (adv) begin
         if (m_mode <= 1) begin
            if (m_lo == int'(lo_cmp)) begin m_lo = 0; slo = 1; end
            else m_lo++;
         end
         if (m_mode == 0) begin
            if (m_hi == int'(hi_cmp)) begin m_hi = 0; shi = 1; end
            else m_hi++;
         end else if (m_mode == 1) begin
            if (m_hi == 255) begin m_hi = 0; shi = 1; m_duty = int'(hi_cmp); end
            else m_hi++;
         end else begin
            v = m_hi * 256 + m_lo;
            lim = (1 << (9 + int'(len_sel))) - 1;
            if ((m_mode == 2 && v == int'(hi_cmp) * 256 + int'(lo_cmp)) ||
                (m_mode == 3 && v >= lim)) begin
               v = 0; shi = 1;
               if (m_mode == 3) m_duty = int'(duty_var);
            end else begin
               slo = (m_lo == 255);
               v = (v + 1) % 65536;
            end
            m_hi = v / 256; m_lo = v % 256;
         end
      end
      m_flo = slo | (m_flo & !clr_lo);
      m_fhi = shi | (m_fhi & !clr_hi);
      e.flo = m_flo; e.fhi = m_fhi; e.tag = tag;
      if (m_mode == 1)      e.pwm = (m_hi < m_duty);
      else if (m_mode == 3) e.pwm = ((m_hi * 256 + m_lo) < m_duty);
      else                  e.pwm = 1'b0;
      q.push_back(e);
      -> ev_push;
   endtask

   // starts and ends at a falling edge
   task automatic run(string tag, int n, int en_div, bit hf, int clr_div);
      for (int i = 0; i < n; i++) begin
         cnt_en    = ((i % en_div) == 0);
         half_tick = hf;
         clr_lo    = (clr_div != 0) && ((i % clr_div) == clr_div - 1);
         clr_hi    = clr_lo;
         step(tag);
         @(negedge clk);
      end
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         done = 1;
         bad++; total++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state visible at the pins
      chk("R1", pwm_out, flag_lo, flag_hi, 1'b0, 1'b0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", pwm_out, flag_lo, flag_hi, 1'b0, 1'b0, 1'b0);

      // split timers
      mode = 2'd0; lo_cmp = 8'd5; hi_cmp = 8'd9;
      run("R2 R11", 40, 1, 0, 0);
      run("R9", 60, 1, 0, 13);
      run("R9", 30, 1, 0, 1);
      fast_sel = 1'b1;
      run("R6", 30, 3, 1, 0);
      fast_sel = 1'b0;

      // timer + 8-bit PWM
      mode = 2'd1; lo_cmp = 8'd20; hi_cmp = 8'd64;
      run("R3", 600, 1, 0, 0);
      run("R3", 30, 1, 0, 11);
      hi_cmp = 8'd200;
      run("R7", 600, 1, 0, 0);
      hi_cmp = 8'd0;
      run("R8", 600, 1, 0, 0);

      // joined timer
      mode = 2'd2; lo_cmp = 8'h23; hi_cmp = 8'h01;
      run("R4 R11", 700, 1, 0, 0);
      fast_sel = 1'b1;
      run("R6", 700, 2, 1, 0);
      fast_sel = 1'b0;

      // variable-length PWM
      mode = 2'd3; len_sel = 3'd0; duty_var = 16'd100;
      run("R5", 1100, 1, 0, 0);
      duty_var = 16'd300;
      run("R7", 600, 1, 0, 0);
      len_sel = 3'd1; duty_var = 16'd0;
      run("R8", 2200, 1, 0, 0);
      len_sel = 3'd2; duty_var = 16'd1500; fast_sel = 1'b1;
      run("R5 R6", 4200, 2, 1, 0);
      fast_sel = 1'b0;
      mode = 2'd0;
      run("R10 R11", 20, 1, 0, 0);

      #1;
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule